// File: doc/BRIEF.md
# Dual-Mode Microprocessor Register Interface

This block is the slave side of a local processor bus. It gives a host microprocessor read and write access to a bank of sixteen 8-bit configuration registers. The register contents feed the rest of the chip through a flat output vector. A static strap input picks one of two bus styles. In the strobe-pair style, the host uses separate active-low read and write strobes and an active-high address latch enable. In the level-and-strobe style, the host uses a read/write level, an active-low data strobe and an active-low address strobe. Both styles share the same physical pins.

Every bus input passes through a two-flop synchroniser before it is decoded, and strobe edges are found on the synchronised copies. An active-low chip select qualifies every access. The block latches the 10-bit address, commits writes on the closing edge of the relevant strobe, and raises a read-enable output that tells the pad logic when to drive the data bus. Addresses outside the implemented bank read as zero, and writes to them are dropped.

Top module: `dual_bus_reg_port`

## Requirements
- R1: `bus_mode` = 0 selects the strobe-pair style and `bus_mode` = 1 selects the level-and-strobe style. A low-to-high transition on `wr_rw` while `rd_ds_n` stays high writes a register only in the strobe-pair style.
- R2: While `cs_n` is high, no register changes and `rdata_oe` stays 0, whatever the strobes do.
- R3: In the strobe-pair style, a rising edge on `wr_rw` (the write strobe) with `cs_n` low stores the `wdata` present at that edge into the register at the latched address.
- R4: In the level-and-strobe style, `rdata_oe` is asserted while `cs_n` and `rd_ds_n` are low and `wr_rw` is 1. A rising edge on `rd_ds_n` while `wr_rw` is 0 and `cs_n` is low stores `wdata` into the register at the latched address. With `wr_rw` at 1, that edge writes nothing.
- R5: The address register follows `addr` while `ale_as` is active and holds its value otherwise. Active means high in the strobe-pair style and low in the level-and-strobe style.
- R6: An active-low `rst_n` asynchronously clears `rdata_oe` to 0 and sets register n (0 to 15) to the byte whose upper nibble is n and whose lower nibble is the bitwise inverse of n. This takes effect without waiting for a clock edge.
- R7: In the strobe-pair style, `rdata_oe` is asserted while `cs_n` and `rd_ds_n` (the read strobe) are both low, and `rdata` carries the register at the latched address.
- R8: Addresses 0x010 and above read as 0x00 on `rdata`. Writes to them change no register.
- R9: A strobe or chip-select change applied between clock edges first shows on `rdata_oe` after the third rising `clk` edge, and not after the second.
- R10: The register at address 0x00F (the last one) can be written and read back, and `cfg_word` bits [8n+7:8n] always show register n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | Bus style strap: 0 strobe-pair, 1 level-and-strobe |
| cs_n | input | 1 | Active-low chip select |
| wr_rw | input | 1 | Write strobe (active low) or read/write level (1 = read) |
| rd_ds_n | input | 1 | Read strobe or data strobe, active low |
| ale_as | input | 1 | Address latch enable / address strobe |
| addr | input | 10 | Register address bus |
| wdata | input | 8 | Write data from the host |
| rdata | output | 8 | Read data toward the pad drivers |
| rdata_oe | output | 1 | Enable for the read-data drivers |
| cfg_word | output | 128 | All register contents, register n in bits [8n+7:8n] |

## Verification
Each bus style is driven through full write and read-back cycles to several addresses, including the last one. Some write and read cycles are run with the chip select high, which separates real gating from strobe-only decoding. The strap is checked by presenting a write-strobe waveform to the level-and-strobe decoder, where it must leave every register untouched. The same test covers a data-strobe pulse with the level at read. Changing the address bus outside the latch window shows whether the address register really holds. Reads and writes above the bank test the zero readback and the dropped write. Sampling the output enable edge by edge after a strobe change measures the synchroniser latency exactly. Dropping reset between clock edges in the middle of a read shows that the reset does not wait for a clock.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

   typedef enum logic {
      BUS_STROBE_PAIR = 1'b0,
      BUS_LEVEL_STROBE = 1'b1
   } bus_style_e;

   // Reset value of register idx: upper nibble idx, lower nibble its inverse
   function automatic logic [15:0] reg_default(input int unsigned idx);
      logic [3:0] n;
      n = 4'(idx);
      return {8'h00, n, ~n};
   endfunction

endpackage

// File: rtl/dbr_sync.sv
module dbr_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] pipe [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= RST_VAL;
               else        pipe[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= RST_VAL;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/dbr_decode.sv
module dbr_decode
   import dbr_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_s,
   input  logic              cs_n_s,
   input  logic              wr_rw_s,
   input  logic              rd_ds_n_s,
   input  logic              ale_s,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic [DATA_W-1:0] wdata_s,
   output logic [ADDR_W-1:0] addr_q,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              oe_q
);

   bus_style_e style;
   logic       wr_prev;
   logic       ds_prev;
   logic       ale_act;
   logic       oe_nxt;

   assign style   = bus_style_e'(mode_s);
   assign wr_data = wdata_s;

   // previous strobe levels for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev <= 1'b1;
         ds_prev <= 1'b1;
      end else begin
         wr_prev <= wr_rw_s;
         ds_prev <= rd_ds_n_s;
      end
   end

   always_comb begin
      case (style)
         BUS_LEVEL_STROBE: begin
            ale_act = ~ale_s;
            wr_en   = ~cs_n_s & rd_ds_n_s & ~ds_prev & ~wr_rw_s;
            oe_nxt  = ~cs_n_s & ~rd_ds_n_s & wr_rw_s;
         end
         default: begin
            ale_act = ale_s;
            wr_en   = ~cs_n_s & wr_rw_s & ~wr_prev;
            oe_nxt  = ~cs_n_s & ~rd_ds_n_s;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (ale_act) addr_q <= addr_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= oe_nxt;
   end

endmodule

// File: rtl/dbr_regfile.sv
module dbr_regfile
   import dbr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_REGS = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   output logic [NUM_REGS*DATA_W-1:0] cfg
);

   logic [DATA_W-1:0] regs [NUM_REGS];

   genvar i;
   generate
      for (i = 0; i < NUM_REGS; i++) begin : g_reg
         localparam logic [DATA_W-1:0] DEF = DATA_W'(reg_default(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[i] <= DEF;
            else if (wr_en && (addr == ADDR_W'(i)))
               regs[i] <= wdata;
         end
         assign cfg[i*DATA_W +: DATA_W] = regs[i];
      end
   endgenerate

   // unmatched addresses fall through to zero
   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (addr == ADDR_W'(k)) rdata = regs[k];
      end
   end

endmodule

// File: rtl/dual_bus_reg_port.sv
module dual_bus_reg_port
   import dbr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NUM_REGS    = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_mode,
   input  logic                       cs_n,
   input  logic                       wr_rw,
   input  logic                       rd_ds_n,
   input  logic                       ale_as,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   output logic                       rdata_oe,
   output logic [NUM_REGS*DATA_W-1:0] cfg_word
);

   localparam int unsigned CTL_W = 5;
   localparam int unsigned BUS_W = ADDR_W + DATA_W;
   // order: mode, cs_n, wr_rw, rd_ds_n, ale_as (idle levels)
   localparam logic [CTL_W-1:0] CTL_IDLE = 5'b0_1_1_1_0;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
         $error("NUM_REGS must fit the address space");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
   endgenerate

   logic [CTL_W-1:0]  ctl_sync;
   logic [BUS_W-1:0]  bus_sync;
   logic              mode_sync;
   logic              cs_sync;
   logic              rw_sync;
   logic              ds_sync;
   logic              ale_sync;
   logic [ADDR_W-1:0] addr_sync;
   logic [DATA_W-1:0] wdata_sync;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data;

   dbr_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_mode, cs_n, wr_rw, rd_ds_n, ale_as}),
      .q     (ctl_sync)
   );

   dbr_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({addr, wdata}),
      .q     (bus_sync)
   );

   assign {mode_sync, cs_sync, rw_sync, ds_sync, ale_sync} = ctl_sync;
   assign {addr_sync, wdata_sync} = bus_sync;

   dbr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_s    (mode_sync),
      .cs_n_s    (cs_sync),
      .wr_rw_s   (rw_sync),
      .rd_ds_n_s (ds_sync),
      .ale_s     (ale_sync),
      .addr_s    (addr_sync),
      .wdata_s   (wdata_sync),
      .addr_q    (addr_q),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .oe_q      (rdata_oe)
   );

   dbr_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr_q),
      .wdata (wr_data),
      .rdata (rdata),
      .cfg   (cfg_word)
   );

endmodule

// File: rtl/dbr_chk.sv
module dbr_chk #(
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_REGS = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       mode_sync,
   input logic                       cs_sync,
   input logic                       rw_sync,
   input logic                       ale_sync,
   input logic                       wr_en,
   input logic [ADDR_W-1:0]          addr_q,
   input logic [DATA_W-1:0]          wr_data,
   input logic [DATA_W-1:0]          rdata,
   input logic                       rdata_oe,
   input logic [NUM_REGS*DATA_W-1:0] cfg_word
);

   localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   logic [IDX_W-1:0]  idx_d;
   logic [DATA_W-1:0] wd_d;
   logic              hit;

   assign hit = (addr_q < ADDR_W'(NUM_REGS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_d <= '0;
         wd_d  <= '0;
      end else begin
         idx_d <= addr_q[IDX_W-1:0];
         wd_d  <= wr_data;
      end
   end

   p_oe_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> $past(!cs_sync));

   p_regs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_word) |-> $past(wr_en));

   p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit) |=> (cfg_word[idx_d*DATA_W +: DATA_W] == wd_d));

   p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sync ? ale_sync : !ale_sync) |=> $stable(addr_q));

   p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (rdata == '0));

   p_level_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sync && rdata_oe) |-> $past(rw_sync));

endmodule

bind dual_bus_reg_port dbr_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .NUM_REGS (NUM_REGS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_sync (mode_sync),
   .cs_sync   (cs_sync),
   .rw_sync   (rw_sync),
   .ale_sync  (ale_sync),
   .wr_en     (wr_en),
   .addr_q    (addr_q),
   .wr_data   (wr_data),
   .rdata     (rdata),
   .rdata_oe  (rdata_oe),
   .cfg_word  (cfg_word)
);

// File: tb/dual_bus_reg_port_test.sv
module dual_bus_reg_port_test;

   localparam int CLK_PERIOD = 10;
   localparam int NREG = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_mode = 1'b0;
   logic         cs_n = 1'b1;
   logic         wr_rw = 1'b1;
   logic         rd_ds_n = 1'b1;
   logic         ale_as = 1'b0;
   logic [9:0]   addr = '0;
   logic [7:0]   wdata = '0;
   logic [7:0]   rdata;
   logic         rdata_oe;
   logic [127:0] cfg_word;

   logic [7:0]   model [NREG];
   int           checks = 0;
   int           errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_bus_reg_port uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_mode (bus_mode),
      .cs_n     (cs_n),
      .wr_rw    (wr_rw),
      .rd_ds_n  (rd_ds_n),
      .ale_as   (ale_as),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .rdata_oe (rdata_oe),
      .cfg_word (cfg_word)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] model_flat();
      logic [127:0] v;
      for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
      return v;
   endfunction

   task automatic model_defaults();
      for (int i = 0; i < NREG; i++) model[i] = {4'(i), ~4'(i)};
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go_idle();
      cs_n    = 1'b1;
      wr_rw   = 1'b1;
      rd_ds_n = 1'b1;
      ale_as  = bus_mode;   // inactive level: low for strobe-pair, high for level-and-strobe
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      bus_mode = mode;
      rst_n = 1'b0;
      go_idle();
      cyc(3);
      rst_n = 1'b1;
      model_defaults();
      cyc(4);
   endtask

   // ---------------- strobe-pair style ----------------
   task automatic sp_latch(input logic [9:0] a);
      addr = a; ale_as = 1'b1; cyc(4);
      ale_as = 1'b0; cyc(1);
   endtask

   task automatic sp_write(input logic [9:0] a, input logic [7:0] d, input logic sel);
      sp_latch(a);
      cs_n = ~sel; wdata = d; wr_rw = 1'b0; cyc(4);
      wr_rw = 1'b1; cyc(4);
      go_idle(); cyc(2);
      if (sel && a < NREG) model[a[3:0]] = d;
   endtask

   task automatic sp_read(input logic [9:0] a, input string req);
      logic [7:0] exp;
      sp_latch(a);
      exp = (a < NREG) ? model[a[3:0]] : 8'h00;
      cs_n = 1'b0; rd_ds_n = 1'b0; cyc(4);
      check({req, " read enable"}, 128'(rdata_oe), 128'(1'b1));
      check({req, " read data"}, 128'(rdata), 128'(exp));
      go_idle(); cyc(4);
      check({req, " enable release"}, 128'(rdata_oe), 128'(1'b0));
   endtask

   // ---------------- level-and-strobe style ----------------
   task automatic ls_write(input logic [9:0] a, input logic [7:0] d);
      addr = a; ale_as = 1'b0; cs_n = 1'b0; wr_rw = 1'b0; wdata = d; cyc(4);
      rd_ds_n = 1'b0; cyc(4);
      rd_ds_n = 1'b1; cyc(4);
      go_idle(); cyc(2);
      if (a < NREG) model[a[3:0]] = d;
   endtask

   task automatic ls_read(input logic [9:0] a, input string req);
      logic [7:0] exp;
      exp = (a < NREG) ? model[a[3:0]] : 8'h00;
      addr = a; ale_as = 1'b0; cs_n = 1'b0; wr_rw = 1'b1; cyc(4);
      rd_ds_n = 1'b0; cyc(4);
      check({req, " read enable"}, 128'(rdata_oe), 128'(1'b1));
      check({req, " read data"}, 128'(rdata), 128'(exp));
      go_idle(); cyc(4);
      check({req, " enable release"}, 128'(rdata_oe), 128'(1'b0));
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_state();
      do_reset(1'b0);
      check("R6 reset enable", 128'(rdata_oe), 128'(1'b0));
      check("R6 reset defaults", cfg_word, model_flat());
   endtask

   task automatic t_sp_write_read();
      sp_write(10'h005, 8'h3C, 1'b1);
      check("R3 cfg after write", cfg_word, model_flat());
      sp_read(10'h005, "R7 reg5");
      sp_write(10'h002, 8'hA7, 1'b1);
      sp_read(10'h002, "R3 reg2");
      sp_read(10'h009, "R7 reg9 default");
   endtask

   task automatic t_last_reg();
      sp_write(10'h00F, 8'h5A, 1'b1);
      check("R10 cfg top byte", cfg_word[127:120], 128'(8'h5A));
      sp_read(10'h00F, "R10 reg15");
   endtask

   task automatic t_cs_gate();
      sp_write(10'h004, 8'hFF, 1'b0);
      check("R2 write without select", cfg_word, model_flat());
      sp_latch(10'h004);
      cs_n = 1'b1; rd_ds_n = 1'b0; cyc(5);
      check("R2 read without select", 128'(rdata_oe), 128'(1'b0));
      go_idle(); cyc(2);
   endtask

   task automatic t_latency();
      sp_latch(10'h003);
      cs_n = 1'b0; rd_ds_n = 1'b0;
      cyc(2);
      check("R9 enable after two edges", 128'(rdata_oe), 128'(1'b0));
      cyc(1);
      check("R9 enable after three edges", 128'(rdata_oe), 128'(1'b1));
      go_idle(); cyc(4);
   endtask

   task automatic t_unimpl();
      sp_write(10'h123, 8'h99, 1'b1);
      check("R8 write above bank", cfg_word, model_flat());
      sp_read(10'h123, "R8 read above bank");
      sp_read(10'h010, "R8 first address above bank");
   endtask

   task automatic t_addr_hold();
      sp_latch(10'h007);
      addr = 10'h00C;   // changes with the latch enable low
      cs_n = 1'b0; rd_ds_n = 1'b0; cyc(4);
      check("R5 address held", 128'(rdata), 128'(model[7]));
      go_idle(); cyc(4);
   endtask

   task automatic t_async_reset();
      sp_write(10'h001, 8'h44, 1'b1);
      sp_latch(10'h001);
      cs_n = 1'b0; rd_ds_n = 1'b0; cyc(4);
      check("R6 enable before reset", 128'(rdata_oe), 128'(1'b1));
      #2 rst_n = 1'b0;
      #1;
      model_defaults();
      check("R6 async enable clear", 128'(rdata_oe), 128'(1'b0));
      check("R6 async defaults", cfg_word, model_flat());
      @(negedge clk);
      go_idle(); cyc(2);
      rst_n = 1'b1; cyc(4);
   endtask

   task automatic t_ls_mode();
      do_reset(1'b1);
      ls_write(10'h00A, 8'hE1);
      check("R4 cfg after write", cfg_word, model_flat());
      ls_read(10'h00A, "R4 regA");
      ls_write(10'h006, 8'h18);
      ls_read(10'h006, "R5 reg6");
      // write-strobe waveform with the data strobe idle: no write here
      addr = 10'h00B; ale_as = 1'b0; cs_n = 1'b0; wdata = 8'h77;
      wr_rw = 1'b0; cyc(4); wr_rw = 1'b1; cyc(4);
      go_idle(); cyc(2);
      check("R1 strobe-pair write ignored", cfg_word, model_flat());
      // data strobe pulse with the level at read: no write
      addr = 10'h00B; ale_as = 1'b0; cs_n = 1'b0; wr_rw = 1'b1; wdata = 8'h66;
      cyc(4); rd_ds_n = 1'b0; cyc(4); rd_ds_n = 1'b1; cyc(4);
      go_idle(); cyc(2);
      check("R4 read strobe no write", cfg_word, model_flat());
      ls_read(10'h200, "R8 level style above bank");
   endtask

   initial begin
      model_defaults();
      t_reset_state();
      t_sp_write_read();
      t_last_reg();
      t_cs_gate();
      t_latency();
      t_unimpl();
      t_addr_hold();
      t_async_reset();
      t_ls_mode();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule